// File: doc/BRIEF.md
# Mechanism-2 PCI Configuration Address Translator

This block sits on the host side of an I/O access path. It holds two byte-wide control registers at I/O port 0CF8h: a mapping-enable register in byte lane 0 and a target-bus register in byte lane 2, which is port 0CFAh. While the key nibble of the enable register is zero, every I/O access is passed through unchanged. When the key is set, any access whose address bits 31:12 equal 0000Ch becomes a configuration request. In that request, address bits 11:8 give the device, bits 7:2 give the register index, the bus comes from the bus register, and the function and cycle kind come from the enable register.

Each accepted access produces exactly one registered result, one cycle after it is presented. That result is a configuration request, a pass-through I/O cycle, or register read data. Register writes produce no output.

Top module: `cfgm2_translator`

## Requirements
- R1: After reset both registers read as zero, mapping is disabled and no output valid is asserted.
- R2: A write to dword 0CF8h loads the enable register from data bits 7:0 when byte enable 0 is set, and loads the bus register from data bits 23:16 when byte enable 2 is set. A read of that dword raises rd_valid one cycle later, with the enable register in bits 7:0, the bus register in bits 23:16 and zeros elsewhere.
- R3: While the key field (enable bits 7:4) is 0000, accesses to C000h–CFFFh appear on the pass-through outputs and raise no configuration request.
- R4: With a nonzero key, an access whose address bits 31:12 equal 0000Ch raises cfg_valid one cycle later. cfg_dev is address bits 11:8, cfg_reg is address bits 7:2, cfg_func is enable bits 3:1 and cfg_bus is the bus register.
- R5: cfg_special equals enable bit 0: 0 for a configuration cycle, 1 for a special cycle.
- R6: Any address that is neither dword 0CF8h nor inside the C000h–CFFFh window passes through, even while mapping is enabled.
- R7: For writes, the write data and byte enables are carried with the request or pass-through cycle. For reads, both are driven as zero. The direction flag follows the access.
- R8: Each access yields exactly one single-cycle result, back-to-back accesses yield one result each, and at most one of cfg_valid, pass_valid and rd_valid is high in any cycle.
- R9: A register write leaves unchanged any register whose byte enable is clear. Writes on byte lanes 1 and 3 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | I/O access present this cycle |
| in_write | input | 1 | 1 = write access |
| in_addr | input | 32 | I/O byte address (dword aligned) |
| in_wdata | input | 32 | Write data |
| in_be | input | 4 | Byte enables |
| cfg_valid | output | 1 | Configuration request pulse |
| cfg_write | output | 1 | Request direction |
| cfg_special | output | 1 | 1 = special cycle |
| cfg_bus | output | 8 | Target bus |
| cfg_dev | output | 4 | Target device |
| cfg_func | output | 3 | Target function |
| cfg_reg | output | 6 | Dword register index |
| cfg_wdata | output | 32 | Request write data |
| cfg_be | output | 4 | Request byte enables |
| pass_valid | output | 1 | Ordinary I/O cycle pulse |
| pass_write | output | 1 | Pass-through direction |
| pass_addr | output | 32 | Pass-through address |
| pass_wdata | output | 32 | Pass-through write data |
| pass_be | output | 4 | Pass-through byte enables |
| rd_valid | output | 1 | Register read data pulse |
| rd_data | output | 32 | Register read data |

## Verification
The hardest case to reach is a translated access that immediately follows a change of the enable register. In that case the function, cycle kind and key must come from the value written one cycle earlier, not from an older one. The stimulus issues register writes and window accesses on consecutive cycles: key on, then special-cycle on, then key off. It also issues back-to-back window accesses with differing devices, so each result must match its own access. Partial-lane writes are followed by read-backs, which show that untouched registers held their value.

// File: rtl/cfgm2_pkg.sv
package cfgm2_pkg;
    localparam int AW     = 32;
    localparam int DW     = 32;
    localparam int BW     = DW / 8;
    localparam int BUS_W  = 8;
    localparam int DEV_W  = 4;
    localparam int FN_W   = 3;
    localparam int IDX_W  = 6;
    localparam int KEY_W  = 4;
    localparam int WIN_LO = 12;
    localparam int EN_LANE  = 0;
    localparam int BUS_LANE = 2;
    localparam logic [AW-1:0]        REG_PORT = 32'h0000_0CF8;
    localparam logic [AW-WIN_LO-1:0] WIN_TAG  = 20'h0000C;

    typedef enum logic [1:0] {ACC_NONE, ACC_REG, ACC_CFG, ACC_PASS} acc_kind_e;

    typedef struct packed {
        logic [KEY_W-1:0] key;
        logic [FN_W-1:0]  func;
        logic             special;
    } enable_t;
endpackage

// File: rtl/cfgm2_regs.sv
module cfgm2_regs
    import cfgm2_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [BW-1:0]     be,
    input  logic [DW-1:0]     wdata,
    output enable_t           en_reg,
    output logic [BUS_W-1:0]  bus_reg
);
    typedef struct packed {
        enable_t          en;
        logic [BUS_W-1:0] bus;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            if (be[EN_LANE])  st_d.en  = enable_t'(wdata[EN_LANE*8 +: 8]);
            if (be[BUS_LANE]) st_d.bus = wdata[BUS_LANE*8 +: BUS_W];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en_reg  = st_q.en;
    assign bus_reg = st_q.bus;

    // R9
    en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !be[EN_LANE]) |=> $stable(st_q.en));
    // R9
    bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !be[BUS_LANE]) |=> $stable(st_q.bus));
endmodule

// File: rtl/cfgm2_decode.sv
module cfgm2_decode
    import cfgm2_pkg::*;
(
    input  logic [AW-1:0]    addr,
    input  enable_t          en_reg,
    output acc_kind_e        kind,
    output logic [DEV_W-1:0] dev,
    output logic [IDX_W-1:0] idx
);
    logic is_reg, in_win, mapped;

    always_comb begin
        is_reg = (addr[AW-1:2] == REG_PORT[AW-1:2]);
        in_win = (addr[AW-1:WIN_LO] == WIN_TAG);
        mapped = (en_reg.key != '0);
        if (is_reg)                kind = ACC_REG;
        else if (in_win && mapped) kind = ACC_CFG;
        else                       kind = ACC_PASS;
        dev = addr[WIN_LO-1 -: DEV_W];
        idx = addr[2 +: IDX_W];
    end
endmodule

// File: rtl/cfgm2_translator.sv
module cfgm2_translator
    import cfgm2_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_write,
    input  logic [AW-1:0]     in_addr,
    input  logic [DW-1:0]     in_wdata,
    input  logic [BW-1:0]     in_be,
    output logic              cfg_valid,
    output logic              cfg_write,
    output logic              cfg_special,
    output logic [BUS_W-1:0]  cfg_bus,
    output logic [DEV_W-1:0]  cfg_dev,
    output logic [FN_W-1:0]   cfg_func,
    output logic [IDX_W-1:0]  cfg_reg,
    output logic [DW-1:0]     cfg_wdata,
    output logic [BW-1:0]     cfg_be,
    output logic              pass_valid,
    output logic              pass_write,
    output logic [AW-1:0]     pass_addr,
    output logic [DW-1:0]     pass_wdata,
    output logic [BW-1:0]     pass_be,
    output logic              rd_valid,
    output logic [DW-1:0]     rd_data
);
    typedef struct packed {
        logic             cv;
        logic             cw;
        logic             csp;
        logic [BUS_W-1:0] cbus;
        logic [DEV_W-1:0] cdev;
        logic [FN_W-1:0]  cfn;
        logic [IDX_W-1:0] cidx;
        logic [DW-1:0]    cdata;
        logic [BW-1:0]    cbe;
        logic             pv;
        logic             pw;
        logic [AW-1:0]    paddr;
        logic [DW-1:0]    pdata;
        logic [BW-1:0]    pbe;
        logic             rv;
        logic [DW-1:0]    rdata;
    } out_t;

    enable_t          en_reg;
    logic [BUS_W-1:0] bus_reg;
    acc_kind_e        kind;
    logic [DEV_W-1:0] dev;
    logic [IDX_W-1:0] idx;
    logic             reg_wr;
    logic [DW-1:0]    wdata_m;
    logic [BW-1:0]    be_m;
    out_t             out_d, out_q;

    cfgm2_decode u_decode (
        .addr   (in_addr),
        .en_reg (en_reg),
        .kind   (kind),
        .dev    (dev),
        .idx    (idx)
    );

    assign reg_wr = in_valid && in_write && (kind == ACC_REG);

    cfgm2_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr),
        .be      (in_be),
        .wdata   (in_wdata),
        .en_reg  (en_reg),
        .bus_reg (bus_reg)
    );

    always_comb begin
        out_d   = '0;
        wdata_m = in_write ? in_wdata : '0;
        be_m    = in_write ? in_be    : '0;
        if (in_valid) begin
            unique case (kind)
                ACC_REG: begin
                    if (!in_write) begin
                        out_d.rv    = 1'b1;
                        out_d.rdata = '0;
                        out_d.rdata[EN_LANE*8 +: 8]      = en_reg;
                        out_d.rdata[BUS_LANE*8 +: BUS_W] = bus_reg;
                    end
                end
                ACC_CFG: begin
                    out_d.cv    = 1'b1;
                    out_d.cw    = in_write;
                    out_d.csp   = en_reg.special;
                    out_d.cbus  = bus_reg;
                    out_d.cdev  = dev;
                    out_d.cfn   = en_reg.func;
                    out_d.cidx  = idx;
                    out_d.cdata = wdata_m;
                    out_d.cbe   = be_m;
                end
                ACC_PASS: begin
                    out_d.pv    = 1'b1;
                    out_d.pw    = in_write;
                    out_d.paddr = in_addr;
                    out_d.pdata = wdata_m;
                    out_d.pbe   = be_m;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign cfg_valid   = out_q.cv;
    assign cfg_write   = out_q.cw;
    assign cfg_special = out_q.csp;
    assign cfg_bus     = out_q.cbus;
    assign cfg_dev     = out_q.cdev;
    assign cfg_func    = out_q.cfn;
    assign cfg_reg     = out_q.cidx;
    assign cfg_wdata   = out_q.cdata;
    assign cfg_be      = out_q.cbe;
    assign pass_valid  = out_q.pv;
    assign pass_write  = out_q.pw;
    assign pass_addr   = out_q.paddr;
    assign pass_wdata  = out_q.pdata;
    assign pass_be     = out_q.pbe;
    assign rd_valid    = out_q.rv;
    assign rd_data     = out_q.rdata;

    // R8
    one_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cfg_valid, pass_valid, rd_valid}));
    // R8
    cfg_from_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_valid || pass_valid || rd_valid) |-> $past(in_valid));
    // R3
    cfg_needs_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |-> ($past(en_reg.key) != '0));
    // R4
    cfg_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |-> (cfg_bus == $past(bus_reg)));
    // R6
    pass_outside_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pass_valid |-> (($past(en_reg.key) == '0) || (pass_addr[AW-1:WIN_LO] != WIN_TAG)));
    // R2
    rd_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (rd_data[EN_LANE*8 +: 8] == $past(en_reg)));
endmodule

// File: tb/test_cfgm2_translator.sv
`timescale 1ns/1ps
module test_cfgm2_translator;
    typedef struct packed {
        logic [1:0]  kind;   // 1 cfg, 2 pass, 3 read
        logic        wr;
        logic        sp;
        logic [7:0]  bus;
        logic [3:0]  dev;
        logic [2:0]  fn;
        logic [5:0]  idx;
        logic [31:0] addr;
        logic [31:0] data;
        logic [3:0]  be;
    } item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, in_write = 1'b0;
    logic [31:0] in_addr = '0, in_wdata = '0;
    logic [3:0]  in_be = '0;
    logic cfg_valid, cfg_write, cfg_special;
    logic [7:0] cfg_bus;
    logic [3:0] cfg_dev;
    logic [2:0] cfg_func;
    logic [5:0] cfg_reg;
    logic [31:0] cfg_wdata;
    logic [3:0]  cfg_be;
    logic pass_valid, pass_write;
    logic [31:0] pass_addr, pass_wdata;
    logic [3:0]  pass_be;
    logic rd_valid;
    logic [31:0] rd_data;

    int tests = 0, fails = 0;
    bit done = 0;
    item_t exp_q[$];
    string tag_q[$];
    logic [7:0] m_en = 8'h00, m_bus = 8'h00;

    always #2.5 clk = ~clk;

    cfgm2_translator i_cfgm2_translator (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_write(in_write),
        .in_addr(in_addr), .in_wdata(in_wdata), .in_be(in_be),
        .cfg_valid(cfg_valid), .cfg_write(cfg_write), .cfg_special(cfg_special),
        .cfg_bus(cfg_bus), .cfg_dev(cfg_dev), .cfg_func(cfg_func), .cfg_reg(cfg_reg),
        .cfg_wdata(cfg_wdata), .cfg_be(cfg_be), .pass_valid(pass_valid),
        .pass_write(pass_write), .pass_addr(pass_addr), .pass_wdata(pass_wdata),
        .pass_be(pass_be), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    task automatic access(input bit wr, input logic [31:0] a, input logic [31:0] d,
                          input logic [3:0] b, input string tag);
        item_t e;
        @(negedge clk);
        in_valid = 1'b1; in_write = wr; in_addr = a; in_wdata = d; in_be = b;
        e = '0;
        if (a[31:2] == 30'h33E) begin
            if (wr) begin
                if (b[0]) m_en  = d[7:0];
                if (b[2]) m_bus = d[23:16];
            end else begin
                e.kind = 2'd3; e.data = {8'h00, m_bus, 8'h00, m_en};
                exp_q.push_back(e); tag_q.push_back(tag);
            end
        end else begin
            e.wr = wr; e.data = wr ? d : '0; e.be = wr ? b : '0;
            if (a[31:12] == 20'h0000C && m_en[7:4] != 4'h0) begin
                e.kind = 2'd1; e.sp = m_en[0]; e.bus = m_bus; e.dev = a[11:8];
                e.fn = m_en[3:1]; e.idx = a[7:2];
            end else begin
                e.kind = 2'd2; e.addr = a;
            end
            exp_q.push_back(e); tag_q.push_back(tag);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0; in_write = 1'b0; in_addr = '0; in_wdata = '0; in_be = '0;
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && (cfg_valid || pass_valid || rd_valid)) begin
            item_t g;
            g = '0;
            if ((32'(cfg_valid) + 32'(pass_valid) + 32'(rd_valid)) > 1) begin
                tests++; fails++;
                $display("FAIL R8: %0d results at once, expected 1",
                         32'(cfg_valid) + 32'(pass_valid) + 32'(rd_valid));
            end
            if (cfg_valid) begin
                g.kind = 2'd1; g.wr = cfg_write; g.sp = cfg_special; g.bus = cfg_bus;
                g.dev = cfg_dev; g.fn = cfg_func; g.idx = cfg_reg;
                g.data = cfg_wdata; g.be = cfg_be;
            end else if (pass_valid) begin
                g.kind = 2'd2; g.wr = pass_write; g.addr = pass_addr;
                g.data = pass_wdata; g.be = pass_be;
            end else begin
                g.kind = 2'd3; g.data = rd_data;
            end
            tests++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL R8: unexpected result got %h expected none", g);
            end else begin
                item_t e;
                string t;
                e = exp_q.pop_front(); t = tag_q.pop_front();
                if (g !== e) begin
                    fails++;
                    $display("FAIL %s: got %h expected %h", t, g, e);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        tests++;
        if (cfg_valid || pass_valid || rd_valid) begin
            fails++;
            $display("FAIL R1: got valids %b%b%b expected 000", cfg_valid, pass_valid, rd_valid);
        end
        access(0, 32'h0000_0CF8, 0, 4'h0, "R1");                 // reset readback
        access(1, 32'h0000_C100, 32'hDEAD_BEEF, 4'hF, "R3");     // disabled: pass
        access(0, 32'h0000_C2FC, 32'h1111_1111, 4'h3, "R3");     // read pass, data zeroed (R7)
        access(1, 32'h0000_0CF8, 32'h0012_00A6, 4'h5, "R2");     // en=A6 bus=12
        access(0, 32'h0000_0CF8, 0, 4'hF, "R2");
        access(1, 32'h0000_C348, 32'h0BAD_F00D, 4'h6, "R4/R7");  // dev3 idx12 fn3
        access(0, 32'h0000_CFFC, 32'h5555_5555, 4'hF, "R4");     // dev F idx 3F
        access(1, 32'h0000_0CF8, 32'h0099_0051, 4'h1, "R9");     // en=51, bus kept
        access(1, 32'h0000_C000, 32'h0000_0001, 4'h1, "R5");     // special right after write
        access(0, 32'h0000_0CF8, 0, 4'h0, "R9");
        access(1, 32'h0001_C000, 32'h1234_5678, 4'hF, "R6");
        access(0, 32'h0000_D000, 0, 4'hF, "R6");
        access(1, 32'h0000_0CFC, 32'hCAFE_0000, 4'hC, "R6");
        access(1, 32'h0000_0CF8, 32'h0077_0091, 4'h4, "R2");     // bus=77 only
        access(0, 32'h0000_C510, 0, 4'h0, "R8");
        access(0, 32'h0000_C614, 0, 4'h0, "R8");
        access(1, 32'h0000_C718, 32'hA5A5_A5A5, 4'h8, "R8");
        access(1, 32'h0000_0CF8, 32'hFFFF_FFFF, 4'hA, "R9");     // lanes 1,3 only
        access(0, 32'h0000_0CF8, 0, 4'h0, "R9");
        access(1, 32'h0000_0CF8, 32'h0000_000E, 4'h1, "R3");     // key off
        access(1, 32'h0000_C400, 32'h0000_00FF, 4'h1, "R3");
        access(1, 32'h0000_0CF8, 32'h0000_00C3, 4'h1, "R5");     // key on, special, fn1
        access(0, 32'h0000_C904, 0, 4'hF, "R5");
        idle(6);
        tests++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL R8: got %0d missing results expected 0", exp_q.size());
        end
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule